// File: doc/BRIEF.md
# IDE Bus-Master DMA Channel

This block is one channel of an IDE bus-master DMA engine. Software reaches it over a small register bus. A command byte sits at offset 0, a status byte at offset 2, and a 32-bit pointer to a descriptor table in memory sits at offset 4. When software sets the start bit, the engine reads descriptors from memory. Each descriptor names a buffer and a byte count. For each descriptor, the engine moves that many bytes between a byte-wide memory port and the drive's data FIFO. The direction bit, captured when the transfer starts, picks which way the bytes go.

When the final descriptor's bytes are used up, the engine waits for the drive to raise its interrupt line. It then sets a sticky interrupt flag and goes idle. Software clears the flag by writing a one to it. A memory error response, or software clearing the start bit, ends the transfer early.

Top module: `ide_dma_channel`

## Requirements
- R1: After reset, the command, status and pointer registers read 0. `mem_req`, `drv_rd_pop`, `drv_wr_push` and `irq` are all low.
- R2: Register reads are combinational. Offset 0 returns the start bit at bit 0 and the direction bit at bit 3, with every other bit 0. Offset 2 returns active (bit 0), error (bit 1) and interrupt (bit 2). Offset 4 returns the 32-bit table pointer that software wrote. Every other offset reads 0.
- R3: A command write with bit 0 set starts a transfer if the start bit was clear and the engine is idle. The active status bit reads 1 from the next cycle until the transfer ends.
- R4: A descriptor is 8 bytes, read in ascending byte order from the table. Bytes 0 to 3 are the buffer address, least significant byte first. Bytes 4 and 5 are the byte count, least significant byte first. Bytes 6 and 7 are flags, and bit 15 of the flags marks the last descriptor. Exactly the counted bytes move, at consecutive addresses from the buffer address.
- R5: With command bit 3 = 1, bytes popped from the drive FIFO are written to memory in order. The direction is captured at the start write, and later command writes that keep start at 1 do not change it.
- R6: With command bit 3 = 0, bytes read from memory are pushed into the drive FIFO in order.
- R7: A descriptor byte count of 0 stands for 65536 bytes.
- R8: After a descriptor without the last marker finishes, the next descriptor is read from the following 8 table bytes.
- R9: The interrupt flag (status bit 2, also driven on `irq`) sets only after the last descriptor's count is used up and `drv_irq` is high. It stays set until a status write with bit 2 = 1. A write of 0 leaves it set.
- R10: Writing start = 0 during a transfer aborts it. No further drive pop or push happens. An outstanding memory access completes, and then the engine goes idle without setting the interrupt flag. The pointer register keeps its value.
- R11: A memory response with `mem_err` high ends the transfer and sets status bit 1. A status write with bit 1 = 1 clears that bit.
- R12: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory access done this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| drv_rd_valid | input | 1 | Drive FIFO has a byte for memory |
| drv_rd_data | input | 8 | Byte from the drive FIFO |
| drv_rd_pop | output | 1 | Takes the byte from the drive FIFO |
| drv_wr_ready | input | 1 | Drive FIFO can accept a byte |
| drv_wr_data | output | 8 | Byte to the drive FIFO |
| drv_wr_push | output | 1 | Pushes a byte into the drive FIFO |
| drv_irq | input | 1 | Drive interrupt request |
| irq | output | 1 | Interrupt flag |

## Verification
Register reads are combinational. The active bit rises one cycle after the start write, so the bench reads status at the falling edge after the write's rising edge. The flag bits change in the cycle after the completing beat or the clearing write, and the bench samples them at a later falling edge. Each beat spends at least one cycle per side, and the bench memory and drive models stall at random. For that reason, completion is not predicted to the cycle. The bench polls the active bit until it clears, under a cycle bound, and then compares buffers, FIFO output and status against values its own functions compute. The memory and FIFO models act at the falling edge and read the design's handshake outputs 1 ns later. Each one therefore sees exactly what the next rising edge takes.

// File: rtl/ide_dma_channel.sv
module ide_dma_channel #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int DSZ = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [7:0]    mem_rdata,
  input  logic          drv_rd_valid,
  input  logic [7:0]    drv_rd_data,
  output logic          drv_rd_pop,
  input  logic          drv_wr_ready,
  output logic [7:0]    drv_wr_data,
  output logic          drv_wr_push,
  input  logic          drv_irq,
  output logic          irq
);
  localparam int IW = $clog2(DSZ);
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_DESC, S_GET, S_PUT, S_WAIT} state_t;

  state_t        st;
  logic          cmd_start, cmd_dir, cur_dir, irq_f, err_f, last_f;
  logic [AW-1:0] tbl_base, tbl_cur, buf_ptr;
  logic [IW-1:0] fidx;
  logic [CW-1:0] cnt_raw;
  logic [CW:0]   remain;
  logic [7:0]    hold;

  wire wr_cmd = reg_wr && reg_addr == 3'd0;
  wire wr_sts = reg_wr && reg_addr == 3'd2;
  wire wr_ptr = reg_wr && reg_addr == 3'd4;
  wire active = st != S_IDLE;
  wire go     = wr_cmd && reg_wdata[0] && !cmd_start && !active;

  assign mem_req     = (st == S_DESC) || (st == S_GET && !cur_dir) || (st == S_PUT && cur_dir);
  assign mem_we      = (st == S_PUT) && cur_dir;
  assign mem_addr    = (st == S_DESC) ? tbl_cur : buf_ptr;
  assign mem_wdata   = hold;
  assign drv_wr_data = hold;
  assign drv_rd_pop  = (st == S_GET) && cur_dir && cmd_start && drv_rd_valid;
  assign drv_wr_push = (st == S_PUT) && !cur_dir && cmd_start && drv_wr_ready;
  assign irq         = irq_f;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {28'd0, cmd_dir, 2'b00, cmd_start};
      3'd2:    reg_rdata = {29'd0, irq_f, err_f, active};
      3'd4:    reg_rdata = 32'(tbl_base);
      default: reg_rdata = 32'd0;
    endcase
  end

  wire put_done = (st == S_PUT) && (cur_dir ? (mem_ack && !mem_err && cmd_start) : drv_wr_push);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd_start <= 1'b0;
      cmd_dir <= 1'b0;
      cur_dir <= 1'b0;
      irq_f <= 1'b0;
      err_f <= 1'b0;
      last_f <= 1'b0;
      tbl_base <= '0;
      tbl_cur <= '0;
      buf_ptr <= '0;
      fidx <= '0;
      cnt_raw <= '0;
      remain <= '0;
      hold <= '0;
    end else begin
      if (wr_cmd) begin
        cmd_start <= reg_wdata[0];
        cmd_dir <= reg_wdata[3];
      end
      if (wr_ptr) tbl_base <= AW'(reg_wdata);
      if (wr_sts && reg_wdata[2]) irq_f <= 1'b0;
      if (wr_sts && reg_wdata[1]) err_f <= 1'b0;
      if (go) begin
        cur_dir <= reg_wdata[3];
        tbl_cur <= tbl_base;
        fidx <= '0;
        st <= S_DESC;
      end
      case (st)
        S_DESC: if (mem_ack) begin
          if (mem_err) begin
            err_f <= 1'b1;
            st <= S_IDLE;
          end else begin
            case (fidx)
              3'd0: buf_ptr[7:0] <= mem_rdata;
              3'd1: buf_ptr[15:8] <= mem_rdata;
              3'd2: buf_ptr[23:16] <= mem_rdata;
              3'd3: buf_ptr[31:24] <= mem_rdata;
              3'd4: cnt_raw[7:0] <= mem_rdata;
              3'd5: cnt_raw[15:8] <= mem_rdata;
              3'd7: last_f <= mem_rdata[7];
              default: ;
            endcase
            tbl_cur <= tbl_cur + 1'b1;
            fidx <= fidx + 1'b1;
            if (!cmd_start) st <= S_IDLE;
            else if (fidx == IW'(DSZ-1)) begin
              remain <= (cnt_raw == '0) ? FULL : {1'b0, cnt_raw};
              st <= S_GET;
            end
          end
        end
        S_GET: begin
          if (cur_dir) begin
            if (!cmd_start) st <= S_IDLE;
            else if (drv_rd_valid) begin
              hold <= drv_rd_data;
              st <= S_PUT;
            end
          end else if (mem_ack) begin
            if (mem_err) begin
              err_f <= 1'b1;
              st <= S_IDLE;
            end else if (!cmd_start) st <= S_IDLE;
            else begin
              hold <= mem_rdata;
              st <= S_PUT;
            end
          end
        end
        S_PUT: begin
          if (cur_dir && mem_ack && mem_err) begin
            err_f <= 1'b1;
            st <= S_IDLE;
          end else if (!cmd_start && (!cur_dir || mem_ack)) st <= S_IDLE;
          else if (put_done) begin
            buf_ptr <= buf_ptr + 1'b1;
            remain <= remain - 1'b1;
            if (remain == 1) st <= last_f ? S_WAIT : S_DESC;
            else st <= S_GET;
          end
        end
        S_WAIT: begin
          if (!cmd_start) st <= S_IDLE;
          else if (drv_irq) begin
            irq_f <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r3_start_fetches: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> mem_req && !mem_we && mem_addr == $past(tbl_base));
  a_r9_irq_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(drv_irq) && $past(st == S_WAIT));
  a_r11_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> st == S_IDLE && err_f);
  a_r7_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GET || st == S_PUT) |-> remain != '0);
endmodule

// File: tb/test_ide_dma_channel.sv
module test_ide_dma_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack, mem_err;
  logic [7:0]  mem_rdata;
  logic        drv_rd_valid;
  logic [7:0]  drv_rd_data;
  logic        drv_rd_pop;
  logic        drv_wr_ready;
  logic [7:0]  drv_wr_data;
  logic        drv_wr_push;
  logic        drv_irq = 1'b1;
  logic        irq;

  ide_dma_channel i_ide_dma_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .drv_rd_valid(drv_rd_valid), .drv_rd_data(drv_rd_data), .drv_rd_pop(drv_rd_pop),
    .drv_wr_ready(drv_wr_ready), .drv_wr_data(drv_wr_data), .drv_wr_push(drv_wr_push),
    .drv_irq(drv_irq), .irq(irq));

  logic [7:0] mem [0:1023];
  logic [7:0] src [0:511];
  logic [7:0] snk [0:511];
  int src_n = 0, src_idx = 0, snk_n = 0, pops = 0, memwr = 0;
  int avail_pct = 100;
  bit err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int n_chk = 0, n_fail = 0, proto_bad = 0;
  bit pop_f = 1'b0, push_f = 1'b0, prev_req = 1'b0, prev_ack = 1'b0;
  logic [7:0] push_d = '0;
  logic [31:0] prev_addr = '0;

  initial begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    drv_rd_valid = 1'b0; drv_rd_data = '0; drv_wr_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (pop_f) begin src_idx++; pops++; end
      if (push_f) begin snk[snk_n] = push_d; snk_n++; end
      if (rst_n && prev_req && !prev_ack && (!mem_req || mem_addr != prev_addr)) proto_bad++;
      if (rst_n && mem_req && !mem_ack && ($urandom % 4 != 0)) begin
        mem_ack = 1'b1;
        mem_err = err_en && mem_addr == err_addr;
        if (mem_we) begin
          if (!mem_err) begin mem[mem_addr[9:0]] = mem_wdata; memwr++; end
        end else mem_rdata = mem[mem_addr[9:0]];
      end else begin
        mem_ack = 1'b0; mem_err = 1'b0;
      end
      drv_rd_valid = (src_idx < src_n) && (($urandom % 100) < avail_pct);
      drv_rd_data = src[src_idx % 512];
      drv_wr_ready = ($urandom % 100) < avail_pct;
      prev_req = mem_req; prev_addr = mem_addr; prev_ack = mem_ack;
      #1;
      pop_f = drv_rd_pop; push_f = drv_wr_push; push_d = drv_wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(input int lim);
    logic [31:0] s;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk); #3;
      rreg(3'd2, s);
      if (!s[0]) break;
    end
  endtask

  task automatic put_desc(input int tbl, input int k, input logic [31:0] b, input logic [15:0] len, input bit last);
    int o;
    o = tbl + 8 * k;
    for (int j = 0; j < 4; j++) mem[o + j] = b[8*j +: 8];
    mem[o + 4] = len[7:0];
    mem[o + 5] = len[15:8];
    mem[o + 6] = 8'h00;
    mem[o + 7] = last ? 8'h80 : 8'h00;
  endtask

  function automatic logic [31:0] exp_sts(input bit ir, input bit er, input bit act);
    return {29'd0, ir, er, act};
  endfunction

  initial begin
    logic [31:0] r;
    void'($urandom(32'h1D3A_5EED));
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    #2;
    rreg(3'd0, r); chk(r == 0, "R1 cmd reset", r, 0);
    rreg(3'd2, r); chk(r == 0, "R1 status reset", r, 0);
    rreg(3'd4, r); chk(r == 0, "R1 ptr reset", r, 0);
    chk(!mem_req && !irq && !drv_rd_pop && !drv_wr_push, "R1 outputs idle",
        {mem_req, irq, drv_rd_pop, drv_wr_push}, 0);
    rst_n = 1'b1;

    wreg(3'd4, 32'hA5C3_0F1E);
    rreg(3'd4, r); chk(r == 32'hA5C3_0F1E, "R2 ptr readback", r, 32'hA5C3_0F1E);
    wreg(3'd0, 32'h0000_00F8);
    rreg(3'd0, r); chk(r == 32'h8, "R2 cmd bits", r, 32'h8);
    rreg(3'd6, r); chk(r == 0, "R2 unused offset", r, 0);
    wreg(3'd0, 0);

    // drive -> memory, two chained descriptors
    put_desc(0, 0, 32'h100, 16'd5, 1'b0);
    put_desc(0, 1, 32'h180, 16'd3, 1'b1);
    for (int i = 0; i < 8; i++) src[i] = 8'($urandom);
    src_n = 8; src_idx = 0; pops = 0; avail_pct = 70; drv_irq = 1'b1;
    wreg(3'd4, 0);
    wreg(3'd0, 9);
    rreg(3'd2, r); chk(r[0], "R3 active after start", r, 1);
    wait_idle(2000);
    for (int i = 0; i < 5; i++)
      chk(mem[16'h100 + i] == src[i], "R5 R4 drive to mem desc0", {24'd0, mem[16'h100 + i]}, {24'd0, src[i]});
    for (int i = 0; i < 3; i++)
      chk(mem[16'h180 + i] == src[5 + i], "R8 second descriptor", {24'd0, mem[16'h180 + i]}, {24'd0, src[5 + i]});
    chk(mem[16'h105] == 0 && mem[16'h183] == 0, "R4 no overrun", {16'd0, mem[16'h105], mem[16'h183]}, 0);
    rreg(3'd2, r); chk(r == exp_sts(1, 0, 0), "R9 done status", r, exp_sts(1, 0, 0));
    chk(irq, "R9 irq port", {31'd0, irq}, 1);
    wreg(3'd0, 8);
    wreg(3'd2, 0);
    rreg(3'd2, r); chk(r[2], "R9 write zero keeps flag", r, 4);
    wreg(3'd2, 4);
    rreg(3'd2, r); chk(r == 0 && !irq, "R9 w1c clears", r, 0);

    // memory -> drive, delayed drive interrupt
    put_desc(16'h40, 0, 32'h200, 16'd6, 1'b1);
    for (int i = 0; i < 6; i++) mem[16'h200 + i] = 8'($urandom);
    snk_n = 0; drv_irq = 1'b0;
    wreg(3'd4, 32'h40);
    wreg(3'd0, 1);
    for (int i = 0; i < 2000 && snk_n < 6; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    #3;
    rreg(3'd2, r); chk(r == exp_sts(0, 0, 1), "R9 waits for drive irq", r, exp_sts(0, 0, 1));
    drv_irq = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    rreg(3'd2, r); chk(r == exp_sts(1, 0, 0), "R9 flag after drive irq", r, exp_sts(1, 0, 0));
    for (int i = 0; i < 6; i++)
      chk(snk[i] == mem[16'h200 + i], "R6 mem to drive", {24'd0, snk[i]}, {24'd0, mem[16'h200 + i]});
    chk(snk_n == 6, "R6 push count", snk_n, 6);
    wreg(3'd0, 0); wreg(3'd2, 4);

    // random transfers
    for (int it = 0; it < 6; it++) begin
      bit dir;
      int nd, off;
      int lens [3];
      dir = 1'($urandom);
      nd = 1 + int'($urandom % 3);
      off = 0;
      avail_pct = 30 + int'($urandom % 71);
      for (int k = 0; k < nd; k++) begin
        lens[k] = 1 + int'($urandom % 24);
        put_desc(0, k, 32'h100 + 32'(64 * k), 16'(lens[k]), k == nd - 1);
        for (int j = 0; j < lens[k]; j++) begin
          src[off + j] = 8'($urandom);
          mem[16'h100 + 64 * k + j] = dir ? 8'h00 : 8'($urandom);
        end
        off += lens[k];
      end
      src_n = dir ? off : 0; src_idx = 0; snk_n = 0;
      wreg(3'd4, 0);
      wreg(3'd0, dir ? 9 : 1);
      if (it == 0) wreg(3'd0, dir ? 1 : 9);
      wait_idle(4000);
      off = 0;
      for (int k = 0; k < nd; k++) begin
        for (int j = 0; j < lens[k]; j++) begin
          if (dir) chk(mem[16'h100 + 64 * k + j] == src[off + j], "R5 random drive to mem",
                       {24'd0, mem[16'h100 + 64 * k + j]}, {24'd0, src[off + j]});
          else chk(snk[off + j] == mem[16'h100 + 64 * k + j], "R6 random mem to drive",
                   {24'd0, snk[off + j]}, {24'd0, mem[16'h100 + 64 * k + j]});
        end
        off += lens[k];
      end
      rreg(3'd2, r); chk(r == exp_sts(1, 0, 0), "R8 random chain done", r, exp_sts(1, 0, 0));
      wreg(3'd0, 0); wreg(3'd2, 4);
    end

    // zero count means 65536, then abort
    put_desc(0, 0, 32'h200, 16'd0, 1'b1);
    for (int i = 0; i < 512; i++) src[i] = 8'($urandom);
    src_n = 512; src_idx = 0; pops = 0; avail_pct = 100;
    wreg(3'd4, 0);
    wreg(3'd0, 9);
    repeat (300) @(negedge clk);
    #3;
    rreg(3'd2, r); chk(r[0] && pops > 8, "R7 zero count keeps running", pops, 9);
    wreg(3'd0, 8);
    repeat (10) @(negedge clk);
    #3;
    rreg(3'd2, r); chk(r == exp_sts(0, 0, 0), "R10 abort goes idle", r, 0);
    begin
      int p, w;
      p = pops; w = memwr;
      repeat (20) @(negedge clk);
      chk(pops == p && memwr == w, "R10 no traffic after abort", pops + memwr, p + w);
    end
    #3;
    rreg(3'd4, r); chk(r == 0, "R10 ptr unchanged", r, 0);

    // memory error
    put_desc(0, 0, 32'h300, 16'd8, 1'b1);
    for (int i = 0; i < 8; i++) mem[16'h300 + i] = 8'h00;
    src_idx = 0; src_n = 8; err_en = 1'b1; err_addr = 32'h303;
    wreg(3'd0, 9);
    wait_idle(2000);
    rreg(3'd2, r); chk(r == exp_sts(0, 1, 0), "R11 error status", r, exp_sts(0, 1, 0));
    chk(mem[16'h303] == 0 && mem[16'h304] == 0, "R11 stop at error",
        {16'd0, mem[16'h303], mem[16'h304]}, 0);
    wreg(3'd2, 2);
    rreg(3'd2, r); chk(r == 0, "R11 w1c error", r, 0);
    err_en = 1'b0;
    wreg(3'd0, 0);

    chk(proto_bad == 0, "R12 request held until ack", proto_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule